// File: doc/BRIEF.md
# Memory protection region checker

The block decides, for every bus access, whether it may proceed. It holds a small table of region descriptors. Each descriptor has an inclusive address window, a valid bit, a rights word covering eight bus masters, a process identifier and a mask for that identifier. An access brings an address, a master number, an access kind (read, write or execute), a supervisor flag and a process identifier. One clock later the block answers with a grant or a denial. A denial carries a cause code that tells a miss apart from a lack of rights.

Masters 0 to 3 are privileged. Each has separate user and supervisor rights and can optionally require a match on the process identifier. Masters 4 to 7 have only a read enable and a write enable. They cannot execute, and the mode flag has no effect on them. Address windows are always rounded out to whole 32-byte blocks. Where windows overlap, one region that grants is enough. A global enable turns all checking off. Descriptors are written through a simple port that replaces one whole descriptor at a time.

Top module: `region_guard`

## Requirements
- R1: The low 5 bits of a written start address are treated as 0 and those of a written end address as 1. An access matches the region when start <= addr <= end.
- R2: For masters 0 to 3, the field of master n sits at bits [6n+5:6n] of the rights word. In user mode, field bits [2:0] allow read (bit 2), write (bit 1) and execute (bit 0). acc_kind encodes 0 = read, 1 = write, 2 = execute.
- R3: For masters 0 to 3 in supervisor mode (acc_super = 1), field bits [4:3] select the rights: 0 = read/write/execute, 1 = read/execute, 2 = read/write, 3 = the user rights of bits [2:0].
- R4: For masters 4 to 7, bit 24+2(n-4) of the rights word is the write enable and the bit above it is the read enable. Execute is always denied, and acc_super has no effect.
- R5: If bit 6n+5 is set for a master n in 0 to 3, the region matches only when acc_pid equals the region identifier on every bit that is clear in the region's mask.
- R6: A region whose valid bit is clear never matches.
- R7: With chk_enable low, every access is granted with cause 0.
- R8: A denied access reports rsp_cause 0 when no region matched, 1 when exactly one matched and 2 when several matched. A granted access reports cause 0.
- R9: With overlapping matches, the access is granted if any one of the matching regions grants the requested kind.
- R10: The verdict for an access sampled at a clock edge appears right after that edge, with rsp_valid high. After a cycle without an access, rsp_valid is low.
- R11: After reset, all regions are invalid and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_enable | input | 1 | Global checking enable |
| cfg_wr | input | 1 | Write strobe for one descriptor |
| cfg_idx | input | 3 | Index of the descriptor being written |
| cfg_start | input | 32 | Region start address |
| cfg_end | input | 32 | Region end address |
| cfg_valid | input | 1 | Region valid bit |
| cfg_rights | input | 32 | Rights word for all masters |
| cfg_pid | input | 8 | Region process identifier |
| cfg_pid_mask | input | 8 | Identifier bits to ignore (1 = ignore) |
| acc_valid | input | 1 | An access is presented |
| acc_addr | input | 32 | Access address |
| acc_master | input | 3 | Requesting master number |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_super | input | 1 | Supervisor mode flag |
| acc_pid | input | 8 | Access process identifier |
| rsp_valid | output | 1 | A verdict is present |
| rsp_grant | output | 1 | Access allowed |
| rsp_cause | output | 2 | Denial cause (0 no hit, 1 single, 2 overlap) |

## Verification
A descriptor write takes effect at the clock edge where the strobe is sampled. An access presented after that edge already sees the new descriptor. Each access is driven on a falling edge, is sampled at the next rising edge and has its verdict registered at that same edge. The bench reads the verdict one nanosecond after that rising edge and never in the same time step as the edge. Accesses in consecutive cycles are each checked in their own cycle, and one idle cycle is checked for rsp_valid low.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int ADDR_W    = 32;
    localparam int GRAN_BITS = 5;
    localparam int PID_W     = 8;
    localparam int RIGHTS_W  = 32;
    localparam int MST_W     = 3;
    localparam int NPRIV     = 4;
    localparam int NNORM     = 4;
    localparam int PRIV_FLD  = 6;
    localparam int NORM_BASE = NPRIV * PRIV_FLD;
    localparam int NORM_FLD  = 2;
    localparam logic [ADDR_W-1:0] GRAN_MASK = ADDR_W'((1 << GRAN_BITS) - 1);

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        CAUSE_NOHIT   = 2'd0,
        CAUSE_SINGLE  = 2'd1,
        CAUSE_OVERLAP = 2'd2
    } cause_e;

    typedef struct packed {
        logic                valid;
        logic [ADDR_W-1:0]   lo;
        logic [ADDR_W-1:0]   hi;
        logic [RIGHTS_W-1:0] rights;
        logic [PID_W-1:0]    pid;
        logic [PID_W-1:0]    pid_mask;
    } region_t;

    typedef struct packed {
        logic   valid;
        logic   grant;
        cause_e cause;
    } verdict_t;
endpackage

// File: rtl/region_store.sv
module region_store
    import mpu_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  region_t          wr_desc,
    output region_t          rgn_q [NREG]
);
    region_t rgn_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            rgn_d[i] = rgn_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                rgn_d[i] = wr_desc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                rgn_q[i] <= '0;
            end
        end else begin
            rgn_q <= rgn_d;
        end
    end
endmodule

// File: rtl/region_match.sv
module region_match
    import mpu_pkg::*;
(
    input  region_t            rgn,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [MST_W-1:0]   acc_master,
    input  logic [1:0]         acc_kind,
    input  logic               acc_super,
    input  logic [PID_W-1:0]   acc_pid,
    output logic               hit,
    output logic               permit
);
    logic [PRIV_FLD-1:0] pfld;
    logic [NORM_FLD-1:0] nfld;
    logic [2:0]          rwx;
    logic                is_priv;
    logic                pid_ok;
    logic                in_range;

    always_comb begin
        pfld = '0;
        nfld = '0;
        for (int i = 0; i < NPRIV; i++) begin
            if (acc_master == MST_W'(i)) begin
                pfld = rgn.rights[PRIV_FLD*i +: PRIV_FLD];
            end
        end
        for (int i = 0; i < NNORM; i++) begin
            if (acc_master == MST_W'(NPRIV + i)) begin
                nfld = rgn.rights[NORM_BASE + NORM_FLD*i +: NORM_FLD];
            end
        end

        is_priv = acc_master < MST_W'(NPRIV);

        // bit order of rwx: [2] read, [1] write, [0] execute
        if (is_priv) begin
            rwx = pfld[2:0];
            if (acc_super) begin
                case (pfld[4:3])
                    2'd0:    rwx = 3'b111;
                    2'd1:    rwx = 3'b101;
                    2'd2:    rwx = 3'b110;
                    default: rwx = pfld[2:0];
                endcase
            end
            pid_ok = !pfld[5] || (((acc_pid ^ rgn.pid) & ~rgn.pid_mask) == '0);
        end else begin
            rwx    = {nfld[1], nfld[0], 1'b0};
            pid_ok = 1'b1;
        end

        in_range = (acc_addr >= rgn.lo) && (acc_addr <= rgn.hi);
        hit      = rgn.valid && in_range && pid_ok;

        case (acc_kind)
            KIND_READ:  permit = hit && rwx[2];
            KIND_WRITE: permit = hit && rwx[1];
            KIND_EXEC:  permit = hit && rwx[0];
            default:    permit = 1'b0;
        endcase
    end
endmodule

// File: rtl/region_guard.sv
module region_guard
    import mpu_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_enable,
    input  logic                cfg_wr,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]   cfg_start,
    input  logic [ADDR_W-1:0]   cfg_end,
    input  logic                cfg_valid,
    input  logic [RIGHTS_W-1:0] cfg_rights,
    input  logic [PID_W-1:0]    cfg_pid,
    input  logic [PID_W-1:0]    cfg_pid_mask,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [MST_W-1:0]    acc_master,
    input  logic [1:0]          acc_kind,
    input  logic                acc_super,
    input  logic [PID_W-1:0]    acc_pid,
    output logic                rsp_valid,
    output logic                rsp_grant,
    output logic [1:0]          rsp_cause
);
    region_t   wr_desc;
    region_t   rgn_q [NREG];
    logic [NREG-1:0] hit_vec;
    logic [NREG-1:0] perm_vec;
    verdict_t  rsp_d, rsp_q;
    logic      several;

    always_comb begin
        wr_desc.valid    = cfg_valid;
        wr_desc.lo       = cfg_start & ~GRAN_MASK;
        wr_desc.hi       = cfg_end | GRAN_MASK;
        wr_desc.rights   = cfg_rights;
        wr_desc.pid      = cfg_pid;
        wr_desc.pid_mask = cfg_pid_mask;
    end

    region_store #(.NREG(NREG)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_idx  (cfg_idx),
        .wr_desc (wr_desc),
        .rgn_q   (rgn_q)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_rgn
        region_match u_match (
            .rgn        (rgn_q[g]),
            .acc_addr   (acc_addr),
            .acc_master (acc_master),
            .acc_kind   (acc_kind),
            .acc_super  (acc_super),
            .acc_pid    (acc_pid),
            .hit        (hit_vec[g]),
            .permit     (perm_vec[g])
        );
    end

    always_comb begin
        several     = (hit_vec & (hit_vec - NREG'(1))) != '0;
        rsp_d.valid = acc_valid;
        rsp_d.grant = 1'b1;
        rsp_d.cause = CAUSE_NOHIT;
        if (chk_enable && (perm_vec == '0)) begin
            rsp_d.grant = 1'b0;
            if (hit_vec == '0) begin
                rsp_d.cause = CAUSE_NOHIT;
            end else if (several) begin
                rsp_d.cause = CAUSE_OVERLAP;
            end else begin
                rsp_d.cause = CAUSE_SINGLE;
            end
        end
        if (!acc_valid) begin
            rsp_d.grant = 1'b0;
            rsp_d.cause = CAUSE_NOHIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_grant = rsp_q.grant;
    assign rsp_cause = rsp_q.cause;
endmodule

// File: rtl/region_guard_sva.sv
module region_guard_sva #(
    parameter int NREG = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            chk_enable,
    input logic            acc_valid,
    input logic [2:0]      acc_master,
    input logic [1:0]      acc_kind,
    input logic [NREG-1:0] hit_vec,
    input logic [NREG-1:0] perm_vec,
    input logic            rsp_valid,
    input logic            rsp_grant,
    input logic [1:0]      rsp_cause
);
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(acc_valid));

    p_grant_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> (rsp_cause == 2'd0));

    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(chk_enable)) |-> rsp_grant);

    p_grant_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant && $past(chk_enable)) |-> ($past(perm_vec) != '0));

    p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant && rsp_cause == 2'd1) |-> ($past($countones(hit_vec)) == 1));

    p_nohit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant && rsp_cause == 2'd0) |-> ($past(hit_vec) == '0));

    p_norm_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(chk_enable && acc_master >= 3'd4 && acc_kind == 2'd2)) |-> !rsp_grant);
endmodule

bind region_guard region_guard_sva #(.NREG(NREG)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_enable (chk_enable),
    .acc_valid  (acc_valid),
    .acc_master (acc_master),
    .acc_kind   (acc_kind),
    .hit_vec    (hit_vec),
    .perm_vec   (perm_vec),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_cause  (rsp_cause)
);

// File: tb/test_region_guard.sv
`timescale 1ns/1ps
module test_region_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_enable = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_start = '0, cfg_end = '0, cfg_rights = '0;
    logic        cfg_valid = 1'b0;
    logic [7:0]  cfg_pid = '0, cfg_pid_mask = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_master = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_super = 1'b0;
    logic [7:0]  acc_pid = '0;
    logic        rsp_valid, rsp_grant;
    logic [1:0]  rsp_cause;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    region_guard i_region_guard (
        .clk(clk), .rst_n(rst_n), .chk_enable(chk_enable),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .cfg_valid(cfg_valid), .cfg_rights(cfg_rights), .cfg_pid(cfg_pid),
        .cfg_pid_mask(cfg_pid_mask), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_master(acc_master), .acc_kind(acc_kind), .acc_super(acc_super),
        .acc_pid(acc_pid), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_cause(rsp_cause)
    );

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

    function automatic logic [31:0] priv(int n, logic [2:0] user, logic [1:0] sup, logic pe);
        return 32'({pe, sup, user}) << (6 * n);
    endfunction

    function automatic logic [31:0] norm(int n, logic rd, logic wr);
        return 32'({rd, wr}) << (24 + 2 * (n - 4));
    endfunction

    task automatic wr_rgn(input logic [2:0] idx, input logic [31:0] s, input logic [31:0] e,
                          input logic v, input logic [31:0] r, input logic [7:0] pid,
                          input logic [7:0] msk);
        @(negedge clk);
        cfg_idx = idx; cfg_start = s; cfg_end = e; cfg_valid = v;
        cfg_rights = r; cfg_pid = pid; cfg_pid_mask = msk; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic probe(input string tag, input logic [2:0] m, input logic [1:0] k,
                         input logic sup, input logic [7:0] pid, input logic [31:0] a,
                         input logic eg, input logic [1:0] ec);
        @(negedge clk);
        acc_valid = 1'b1; acc_master = m; acc_kind = k; acc_super = sup;
        acc_pid = pid; acc_addr = a;
        @(posedge clk);
        #1;
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_grant !== eg || rsp_cause !== (eg ? 2'd0 : ec)) begin
            n_fail++;
            $display("FAIL %s: addr=%h m=%0d k=%0d got v=%b g=%b c=%0d exp v=1 g=%b c=%0d",
                     tag, a, m, k, rsp_valid, rsp_grant, rsp_cause, eg, eg ? 2'd0 : ec);
        end
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        acc_valid = 1'b0;
        @(posedge clk);
        #1;
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: rsp_valid got %b exp 0", tag, rsp_valid);
        end
    endtask

    task automatic t_reset;
        #1;
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset: rsp_valid got %b exp 0", rsp_valid);
        end
        probe("R11 all regions invalid", 3'd0, RD, 1'b1, 8'h00, 32'h1000_0000, 1'b0, 2'd0);
    endtask

    task automatic t_granularity;
        wr_rgn(3'd0, 32'h1000_0013, 32'h1000_0041, 1'b1, priv(0, 3'd7, 2'd3, 1'b0), 8'h0, 8'h0);
        probe("R1 low bound rounded down", 3'd0, RD, 1'b0, 8'h0, 32'h1000_0000, 1'b1, 2'd0);
        probe("R1 high bound inclusive",   3'd0, RD, 1'b0, 8'h0, 32'h1000_005F, 1'b1, 2'd0);
        probe("R1 above end",              3'd0, RD, 1'b0, 8'h0, 32'h1000_0060, 1'b0, 2'd0);
        probe("R1 below start",            3'd0, RD, 1'b0, 8'h0, 32'h0FFF_FFFC, 1'b0, 2'd0);
    endtask

    task automatic t_priv_rights;
        wr_rgn(3'd1, 32'h2000_0000, 32'h2000_00FF, 1'b1,
               priv(0, 3'd4, 2'd3, 1'b0) | priv(1, 3'd0, 2'd1, 1'b0) |
               priv(2, 3'd0, 2'd2, 1'b0) | priv(3, 3'd1, 2'd3, 1'b0), 8'h0, 8'h0);
        probe("R2 user read allowed",   3'd0, RD, 1'b0, 8'h0, 32'h2000_0010, 1'b1, 2'd0);
        probe("R2 user write denied",   3'd0, WR, 1'b0, 8'h0, 32'h2000_0010, 1'b0, 2'd1);
        probe("R2 user exec denied",    3'd0, EX, 1'b0, 8'h0, 32'h2000_0010, 1'b0, 2'd1);
        probe("R3 sup=3 follows user",  3'd0, WR, 1'b1, 8'h0, 32'h2000_0010, 1'b0, 2'd1);
        probe("R3 sup=1 exec",          3'd1, EX, 1'b1, 8'h0, 32'h2000_0010, 1'b1, 2'd0);
        probe("R3 sup=1 no write",      3'd1, WR, 1'b1, 8'h0, 32'h2000_0010, 1'b0, 2'd1);
        probe("R3 user side of m1",     3'd1, RD, 1'b0, 8'h0, 32'h2000_0010, 1'b0, 2'd1);
        probe("R3 sup=2 write",         3'd2, WR, 1'b1, 8'h0, 32'h2000_0010, 1'b1, 2'd0);
        probe("R3 sup=2 no exec",       3'd2, EX, 1'b1, 8'h0, 32'h2000_0010, 1'b0, 2'd1);
        probe("R3 sup=3 user exec",     3'd3, EX, 1'b1, 8'h0, 32'h2000_0010, 1'b1, 2'd0);
        probe("R3 sup=3 user no read",  3'd3, RD, 1'b1, 8'h0, 32'h2000_0010, 1'b0, 2'd1);
    endtask

    task automatic t_norm_rights;
        wr_rgn(3'd2, 32'h3000_0000, 32'h3000_00FF, 1'b1,
               norm(4, 1'b0, 1'b1) | norm(5, 1'b1, 1'b0), 8'h0, 8'h0);
        probe("R4 m4 write user",   3'd4, WR, 1'b0, 8'h0, 32'h3000_0040, 1'b1, 2'd0);
        probe("R4 m4 write super",  3'd4, WR, 1'b1, 8'h0, 32'h3000_0040, 1'b1, 2'd0);
        probe("R4 m4 read denied",  3'd4, RD, 1'b1, 8'h0, 32'h3000_0040, 1'b0, 2'd1);
        probe("R4 m4 exec denied",  3'd4, EX, 1'b1, 8'h0, 32'h3000_0040, 1'b0, 2'd1);
        probe("R4 m5 read super",   3'd5, RD, 1'b1, 8'h0, 32'h3000_0040, 1'b1, 2'd0);
        probe("R4 m5 write denied", 3'd5, WR, 1'b0, 8'h0, 32'h3000_0040, 1'b0, 2'd1);
        probe("R4 m5 exec denied",  3'd5, EX, 1'b0, 8'h0, 32'h3000_0040, 1'b0, 2'd1);
    endtask

    task automatic t_pid;
        wr_rgn(3'd3, 32'h4000_0000, 32'h4000_00FF, 1'b1, priv(3, 3'd7, 2'd3, 1'b1), 8'hA5, 8'h0F);
        probe("R5 masked low nibble",   3'd3, RD, 1'b0, 8'hA0, 32'h4000_0020, 1'b1, 2'd0);
        probe("R5 high bit mismatch",   3'd3, RD, 1'b0, 8'hB5, 32'h4000_0020, 1'b0, 2'd0);
        probe("R5 swapped nibbles",     3'd3, RD, 1'b0, 8'h5A, 32'h4000_0020, 1'b0, 2'd0);
        probe("R5 no pid check for m0", 3'd0, RD, 1'b0, 8'h00, 32'h4000_0020, 1'b0, 2'd1);
        wr_rgn(3'd3, 32'h4000_0000, 32'h4000_00FF, 1'b0, priv(3, 3'd7, 2'd3, 1'b1), 8'hA5, 8'h0F);
        probe("R6 invalid region",      3'd3, RD, 1'b0, 8'hA5, 32'h4000_0020, 1'b0, 2'd0);
    endtask

    task automatic t_overlap;
        wr_rgn(3'd4, 32'h5000_0000, 32'h5000_00FF, 1'b1, priv(0, 3'd4, 2'd3, 1'b0), 8'h0, 8'h0);
        wr_rgn(3'd5, 32'h5000_0080, 32'h5000_01FF, 1'b1, priv(0, 3'd2, 2'd3, 1'b0), 8'h0, 8'h0);
        probe("R9 read via first",      3'd0, RD, 1'b0, 8'h0, 32'h5000_0090, 1'b1, 2'd0);
        probe("R9 write via second",    3'd0, WR, 1'b0, 8'h0, 32'h5000_0090, 1'b1, 2'd0);
        probe("R8 overlap none grants", 3'd0, EX, 1'b0, 8'h0, 32'h5000_0090, 1'b0, 2'd2);
        probe("R8 single region deny",  3'd0, WR, 1'b0, 8'h0, 32'h5000_0010, 1'b0, 2'd1);
        probe("R8 single region deny2", 3'd0, RD, 1'b0, 8'h0, 32'h5000_0150, 1'b0, 2'd1);
        idle_check("R10 idle cycle");
    endtask

    task automatic t_bypass;
        @(negedge clk);
        chk_enable = 1'b0;
        probe("R7 bypass grants",  3'd6, EX, 1'b0, 8'h0, 32'hDEAD_0000, 1'b1, 2'd0);
        @(negedge clk);
        chk_enable = 1'b1;
        probe("R7 checking resumes", 3'd6, EX, 1'b0, 8'h0, 32'hDEAD_0000, 1'b0, 2'd0);
        idle_check("R10 idle after access");
    endtask

    initial begin
        #100000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_granularity();
        t_priv_rights();
        t_norm_rights();
        t_pid();
        t_overlap();
        t_bypass();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule